// File: doc/BRIEF.md
# Regulator control register bank on an I2C target

This block is the serial control port of a programmable step-down regulator. It watches the two wires of an I2C bus through an oversampling system clock, recognises start, repeated start and stop conditions, answers to one fixed 7-bit target address, and lets a bus controller write or read one 8-bit register per transaction. The only thing it drives onto the bus is an output enable that pulls SDA low; the pad and pull-up are outside.

Six registers sit behind the port: two output-voltage setpoints (an enable bit over a 7-bit code), a control register, two fixed identity bytes and a status byte assembled from live status inputs plus a sticky flag that records a soft reset. The setpoints and control byte leave the block as parallel outputs for the regulator core. A controller that opens with the high-speed master code is left unacknowledged and the block flags high-speed operation until the next stop; transactions that follow a repeated start in that mode behave as usual.

Top module: `vreg_i2c_target`

## Requirements
- R1: After reset, sel0_o is {1, SEL0_CODE} (0xDA by default), sel1_o is {1, SEL1_CODE} (0xDA by default), ctrl_o is 0x82, sda_oe_o is 0 and hs_mode_o is 0.
- R2: A transaction START, 0xC0, register address, data byte, STOP gets an ACK (SDA held low in the ninth clock) after each of its three bytes, and the addressed writable register (0x00 setpoint 0, 0x01 setpoint 1, 0x02 control) takes the data byte.
- R3: An address byte whose upper seven bits differ from 1100000 gets no ACK and changes no register.
- R4: START, 0xC0, register address, REPEATED START, 0xC1 returns the register contents MSB first on SDA; address 0x03 returns 0x81 and 0x04 returns 0x08.
- R5: Control bits 3 and 2 always read 0 and are never stored, whatever was written.
- R6: Writing the control register with bit 2 set returns every writable register to its reset value; the other written bits are discarded.
- R7: The status register (0x05) reads {status_i[6:2], flag, status_i[1:0]}, where flag (bit 2) is 0 after reset, set by a soft reset and cleared once register 0x05 has been read.
- R8: A first byte of the form 00001xxx after a START (not a repeated start) is not acknowledged; hs_mode_o then stays 1 until the next STOP, and transactions opened by a repeated start meanwhile work as in R2.
- R9: Writes to 0x03..0xFF are acknowledged and change nothing; reads of 0x06..0xFF return 0x00.
- R10: A pulse of two system clocks or fewer on SCL or SDA is ignored, so a short SDA dip while SCL is high neither starts nor stops a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level from the pad |
| sda_i | input | 1 | Bus data level from the pad |
| status_i | input | 7 | Live regulator status, placed in status register bits 7:3 and 1:0 |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| hs_mode_o | output | 1 | High-speed mode announced and not yet ended by STOP |
| sel0_o | output | 8 | Setpoint register 0 |
| sel1_o | output | 8 | Setpoint register 1 |
| ctrl_o | output | 8 | Control register |

## Verification
A wrong bus-controller state shows at the pins within one bit time: a missing or misplaced ACK, SDA driven while the controller owns it, or read data shifted by a bit. A wrong register file state shows on the parallel setpoint and control outputs from the clock edge after the faulty write, which the bench compares against its model on every clock while the bus is idle, and on the status byte the next time register 0x05 is read. The sticky reset flag is checked on two consecutive reads, so a flag that fails to clear or fails to set differs on the second read.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA
  } bus_st_e;

  localparam logic [7:0] RA_SEL0 = 8'h00;
  localparam logic [7:0] RA_SEL1 = 8'h01;
  localparam logic [7:0] RA_CTRL = 8'h02;
  localparam logic [7:0] RA_ID1  = 8'h03;
  localparam logic [7:0] RA_ID2  = 8'h04;
  localparam logic [7:0] RA_MON  = 8'h05;

  localparam logic [7:0] CTRL_RESET   = 8'h82;
  localparam logic [7:0] CTRL_STORE_M = 8'hF3;
  localparam int         CTRL_SRST    = 2;
  localparam logic [7:0] ID1_VALUE    = 8'h81;
  localparam logic [7:0] ID2_VALUE    = 8'h08;
  localparam logic [4:0] HS_CODE_TOP  = 5'b00001;
endpackage

// File: rtl/i2ct_pin_filter.sv
module i2ct_pin_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;
  logic                   level_q, level_d;

  always_comb begin
    level_d = level_q;
    if (&hist_q)       level_d = 1'b1;
    else if (~|hist_q) level_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      hist_q  <= '1;
      level_q <= 1'b1;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], pin_i};
      hist_q  <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      level_q <= level_d;
    end
  end

  assign level_o = level_q;

  // R10: the filtered level only moves after FILT_LEN equal samples
  p_filter_agree_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != $past(level_q)) |-> ($past(hist_q) == {FILT_LEN{level_q}}));
endmodule

// File: rtl/i2ct_bus_ctrl.sv
module i2ct_bus_ctrl
  import i2ct_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'b1100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_f,
  input  logic       sda_f,
  input  logic [7:0] rd_data_i,
  output logic       sda_oe_o,
  output logic       hs_mode_o,
  output logic       wr_en_o,
  output logic       rd_en_o,
  output logic [7:0] reg_ptr_o,
  output logic [7:0] wr_data_o
);
  bus_st_e    state_q, state_d;
  logic [3:0] bitcnt_q, bitcnt_d;
  logic [7:0] shift_q, shift_d;
  logic [7:0] ptr_q, ptr_d;
  logic       oe_q, oe_d;
  logic       hs_q, hs_d;
  logic       busy_q, busy_d;
  logic       fresh_q, fresh_d;
  logic       read_q, read_d;
  logic       skip_q, skip_d;
  logic       scl_q, sda_q;
  logic       start_det, stop_det, scl_rise, scl_fall, byte_end;

  assign start_det = scl_f && scl_q && sda_q && !sda_f;
  assign stop_det  = scl_f && scl_q && !sda_q && sda_f;
  assign scl_rise  = scl_f && !scl_q;
  assign scl_fall  = !scl_f && scl_q;
  assign byte_end  = scl_fall && (bitcnt_q == 4'd8);

  always_comb begin
    state_d  = state_q;
    bitcnt_d = bitcnt_q;
    shift_d  = shift_q;
    ptr_d    = ptr_q;
    oe_d     = oe_q;
    hs_d     = hs_q;
    busy_d   = busy_q;
    fresh_d  = fresh_q;
    read_d   = read_q;
    skip_d   = skip_q;
    wr_en_o  = 1'b0;
    rd_en_o  = 1'b0;
    if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
      hs_d    = 1'b0;
      busy_d  = 1'b0;
      skip_d  = 1'b0;
    end else if (start_det) begin
      state_d  = ST_ADDR;
      bitcnt_d = 4'd0;
      oe_d     = 1'b0;
      fresh_d  = !busy_q;
      busy_d   = 1'b1;
      skip_d   = 1'b0;
    end else if (!skip_q) begin
      unique case (state_q)
        ST_ADDR, ST_REG, ST_WDATA: begin
          if (scl_rise) begin
            shift_d  = {shift_q[6:0], sda_f};
            bitcnt_d = bitcnt_q + 4'd1;
          end else if (byte_end) begin
            bitcnt_d = 4'd0;
            if (state_q == ST_ADDR) begin
              if (fresh_q && shift_q[7:3] == HS_CODE_TOP) begin
                hs_d   = 1'b1;
                skip_d = 1'b1;
              end else if (shift_q[7:1] == TARGET_ADDR) begin
                read_d  = shift_q[0];
                oe_d    = 1'b1;
                state_d = ST_ADDR_ACK;
              end else begin
                skip_d = 1'b1;
              end
            end else if (state_q == ST_REG) begin
              ptr_d   = shift_q;
              oe_d    = 1'b1;
              state_d = ST_REG_ACK;
            end else begin
              wr_en_o = 1'b1;
              oe_d    = 1'b1;
              state_d = ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: if (scl_fall) begin
          bitcnt_d = 4'd0;
          if (read_q) begin
            rd_en_o = 1'b1;
            shift_d = rd_data_i;
            oe_d    = !rd_data_i[7];
            state_d = ST_RDATA;
          end else begin
            oe_d    = 1'b0;
            state_d = ST_REG;
          end
        end
        ST_REG_ACK: if (scl_fall) begin
          oe_d    = 1'b0;
          state_d = ST_WDATA;
        end
        ST_WDATA_ACK: if (scl_fall) begin
          oe_d   = 1'b0;
          skip_d = 1'b1;
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bitcnt_d = bitcnt_q + 4'd1;
          end else if (byte_end) begin
            oe_d   = 1'b0;
            skip_d = 1'b1;
          end else if (scl_fall) begin
            shift_d = {shift_q[6:0], 1'b0};
            oe_d    = !shift_q[6];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      shift_q  <= '0;
      ptr_q    <= '0;
      oe_q     <= 1'b0;
      hs_q     <= 1'b0;
      busy_q   <= 1'b0;
      fresh_q  <= 1'b0;
      read_q   <= 1'b0;
      skip_q   <= 1'b0;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
      shift_q  <= shift_d;
      ptr_q    <= ptr_d;
      oe_q     <= oe_d;
      hs_q     <= hs_d;
      busy_q   <= busy_d;
      fresh_q  <= fresh_d;
      read_q   <= read_d;
      skip_q   <= skip_d;
      scl_q    <= scl_f;
      sda_q    <= sda_f;
    end
  end

  assign sda_oe_o  = oe_q;
  assign hs_mode_o = hs_q;
  assign reg_ptr_o = ptr_q;
  assign wr_data_o = shift_q;

  // R8: high-speed flag drops on every STOP
  p_hs_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !hs_q);
  // R3, R8: a byte that is not ours, or the master code, is never driven
  p_skip_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    skip_q |-> !oe_q);
  // R2: the bus is released whenever no transaction is open
  p_idle_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !oe_q);
  // R2: a write strobe is followed by the data ACK
  p_write_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> oe_q);
endmodule

// File: rtl/i2ct_regs.sv
module i2ct_regs
  import i2ct_pkg::*;
#(
  parameter logic [6:0] SEL0_CODE = 7'h5A,
  parameter logic [6:0] SEL1_CODE = 7'h5A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic [6:0] status_i,
  output logic [7:0] rdata_o,
  output logic [7:0] sel0_o,
  output logic [7:0] sel1_o,
  output logic [7:0] ctrl_o
);
  localparam logic [7:0] SEL0_RESET = {1'b1, SEL0_CODE};
  localparam logic [7:0] SEL1_RESET = {1'b1, SEL1_CODE};

  logic [7:0] sel0_q, sel0_d, sel1_q, sel1_d, ctrl_q, ctrl_d;
  logic       flag_q, flag_d;
  logic       soft_rst;

  assign soft_rst = wr_en_i && (addr_i == RA_CTRL) && wdata_i[CTRL_SRST];

  always_comb begin
    sel0_d = sel0_q;
    sel1_d = sel1_q;
    ctrl_d = ctrl_q;
    flag_d = flag_q;
    if (rd_en_i && addr_i == RA_MON) flag_d = 1'b0;
    if (soft_rst) begin
      sel0_d = SEL0_RESET;
      sel1_d = SEL1_RESET;
      ctrl_d = CTRL_RESET;
      flag_d = 1'b1;
    end else if (wr_en_i) begin
      unique case (addr_i)
        RA_SEL0: sel0_d = wdata_i;
        RA_SEL1: sel1_d = wdata_i;
        RA_CTRL: ctrl_d = wdata_i & CTRL_STORE_M;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (addr_i)
      RA_SEL0: rdata_o = sel0_q;
      RA_SEL1: rdata_o = sel1_q;
      RA_CTRL: rdata_o = ctrl_q;
      RA_ID1:  rdata_o = ID1_VALUE;
      RA_ID2:  rdata_o = ID2_VALUE;
      RA_MON:  rdata_o = {status_i[6:2], flag_q, status_i[1:0]};
      default: rdata_o = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel0_q <= SEL0_RESET;
      sel1_q <= SEL1_RESET;
      ctrl_q <= CTRL_RESET;
      flag_q <= 1'b0;
    end else begin
      sel0_q <= sel0_d;
      sel1_q <= sel1_d;
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
    end
  end

  assign sel0_o = sel0_q;
  assign sel1_o = sel1_q;
  assign ctrl_o = ctrl_q;

  // R5: control bits 3 and 2 are never held
  p_ctrl_zero_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[3:2] == 2'b00);
  // R6: soft reset reloads every writable register and raises the flag
  p_soft_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (sel0_q == SEL0_RESET && sel1_q == SEL1_RESET &&
                  ctrl_q == CTRL_RESET && flag_q));
  // R7: reading the status register clears the flag
  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == RA_MON) |=> !flag_q);
  // R9: a write elsewhere leaves the writable registers untouched
  p_ro_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i > RA_CTRL) |=> $stable(sel0_q) && $stable(sel1_q) && $stable(ctrl_q));
endmodule

// File: rtl/vreg_i2c_target.sv
module vreg_i2c_target #(
  parameter logic [6:0] TARGET_ADDR = 7'b1100000,
  parameter logic [6:0] SEL0_CODE   = 7'h5A,
  parameter logic [6:0] SEL1_CODE   = 7'h5A,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [6:0] status_i,
  output logic       sda_oe_o,
  output logic       hs_mode_o,
  output logic [7:0] sel0_o,
  output logic [7:0] sel1_o,
  output logic [7:0] ctrl_o
);
  localparam int NPINS = 2;

  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic [NPINS-1:0] pins_raw, pins_flt;
  logic             wr_en, rd_en;
  logic [7:0]       reg_ptr, wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign pins_raw = {sda_i, scl_i};

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    i2ct_pin_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .pin_i  (pins_raw[g]),
      .level_o(pins_flt[g])
    );
  end

  i2ct_bus_ctrl #(.TARGET_ADDR(TARGET_ADDR)) u_bus (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .scl_f    (pins_flt[0]),
    .sda_f    (pins_flt[1]),
    .rd_data_i(rd_data),
    .sda_oe_o (sda_oe_o),
    .hs_mode_o(hs_mode_o),
    .wr_en_o  (wr_en),
    .rd_en_o  (rd_en),
    .reg_ptr_o(reg_ptr),
    .wr_data_o(wr_data)
  );

  i2ct_regs #(.SEL0_CODE(SEL0_CODE), .SEL1_CODE(SEL1_CODE)) u_regs (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en_i (wr_en),
    .rd_en_i (rd_en),
    .addr_i  (reg_ptr),
    .wdata_i (wr_data),
    .status_i(status_i),
    .rdata_o (rd_data),
    .sel0_o  (sel0_o),
    .sel1_o  (sel1_o),
    .ctrl_o  (ctrl_o)
  );
endmodule

// File: tb/vreg_i2c_target_tb_top.sv
module vreg_i2c_target_tb_top;
  localparam int Q = 20;
  localparam logic [7:0] DEF_SEL = 8'hDA;
  localparam logic [7:0] DEF_CTRL = 8'h82;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic [6:0] st = 7'h00;
  logic sda_oe, hs_mode, sda_bus;
  logic [7:0] sel0, sel1, ctrl;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit settled = 1'b0;
  bit done = 1'b0;

  logic [7:0] m_r0 = DEF_SEL, m_r1 = DEF_SEL, m_r2 = DEF_CTRL;
  bit m_flag = 1'b0;

  always #10 clk = ~clk;

  assign sda_bus = m_sda & ~sda_oe;

  vreg_i2c_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .status_i(st), .sda_oe_o(sda_oe), .hs_mode_o(hs_mode),
    .sel0_o(sel0), .sel1_o(sel1), .ctrl_o(ctrl));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model compared on every clock while the bus is idle
  always @(negedge clk) begin
    cyc++;
    if (settled && rst_n) begin
      n_chk++;
      if (sel0 !== m_r0 || sel1 !== m_r1 || ctrl !== m_r2 || hs_mode !== 1'b0 || sda_oe !== 1'b0) begin
        n_fail++;
        $display("FAIL R2/R6 model actual=%h %h %h hs=%b oe=%b expected=%h %h %h hs=0 oe=0",
                 sel0, sel1, ctrl, hs_mode, sda_oe, m_r0, m_r1, m_r2);
      end
    end
    if (cyc > 190000 && !done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<190000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    settled = 1'b0;
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_rstart();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(3 * Q);
  endtask

  task automatic put_bit(input logic b, input bit glitch, output logic seen);
    m_sda = b; tick(Q);
    m_scl = 1'b1;
    if (glitch && b) begin
      tick(5); m_sda = 1'b0; tick(2); m_sda = 1'b1; tick(Q - 7);
    end else tick(Q);
    seen = sda_bus;
    tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input int glitch_bit, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) put_bit(b[i], (i == glitch_bit), s);
    put_bit(1'b1, 1'b0, s);
    ack = ~s;
  endtask

  task automatic recv_byte(output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      put_bit(1'b1, 1'b0, s);
      d[i] = s;
    end
    put_bit(1'b1, 1'b0, s);
  endtask

  task automatic settle();
    tick(10);
    settled = 1'b1;
    tick(20);
  endtask

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'h02 && d[2]) begin
      m_r0 = DEF_SEL; m_r1 = DEF_SEL; m_r2 = DEF_CTRL; m_flag = 1'b1;
    end else if (a == 8'h00) m_r0 = d;
    else if (a == 8'h01) m_r1 = d;
    else if (a == 8'h02) m_r2 = d & 8'hF3;
  endtask

  task automatic write_reg(input string tag, input logic [7:0] a, input logic [7:0] d, input int glitch_bit);
    logic ack;
    bus_start();
    send_byte(8'hC0, -1, ack); check({tag, " addr ack"}, ack, 1'b1);
    send_byte(a, -1, ack);     check({tag, " reg ack"}, ack, 1'b1);
    send_byte(d, glitch_bit, ack); check({tag, " data ack"}, ack, 1'b1);
    bus_stop();
    model_write(a, d);
    settle();
  endtask

  task automatic read_reg(input string tag, input logic [7:0] a, input logic [7:0] exp);
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte(8'hC0, -1, ack); check({tag, " addr ack"}, ack, 1'b1);
    send_byte(a, -1, ack);     check({tag, " reg ack"}, ack, 1'b1);
    bus_rstart();
    send_byte(8'hC1, -1, ack); check({tag, " raddr ack"}, ack, 1'b1);
    recv_byte(d);
    check({tag, " read data"}, d, exp);
    bus_stop();
    if (a == 8'h05) m_flag = 1'b0;
    settle();
  endtask

  initial begin
    logic ack;
    tick(5);
    rst_n = 1'b1;
    tick(10);
    // R1: reset values
    check("R1 sel0", sel0, DEF_SEL);
    check("R1 sel1", sel1, DEF_SEL);
    check("R1 ctrl", ctrl, DEF_CTRL);
    check("R1 oe", sda_oe, 1'b0);
    check("R1 hs", hs_mode, 1'b0);
    settle();

    // R2: writes to setpoints
    write_reg("R2 w0", 8'h00, 8'h2A, -1);
    check("R2 sel0", sel0, 8'h2A);
    write_reg("R2 w1", 8'h01, 8'hFF, -1);
    check("R2 sel1", sel1, 8'hFF);

    // R4: reads
    read_reg("R4 r0", 8'h00, 8'h2A);
    read_reg("R4 id1", 8'h03, 8'h81);
    read_reg("R4 id2", 8'h04, 8'h08);

    // R5: bits 3 and 2 of control not stored
    write_reg("R5 wc", 8'h02, 8'h7B, -1);
    check("R5 ctrl", ctrl, 8'h73);
    read_reg("R5 rc", 8'h02, 8'h73);

    // R3: foreign address not acknowledged
    bus_start();
    send_byte(8'hA0, -1, ack); check("R3 nack", ack, 1'b0);
    send_byte(8'h00, -1, ack); check("R3 no reg ack", ack, 1'b0);
    send_byte(8'h11, -1, ack);
    bus_stop();
    settle();
    check("R3 sel0 kept", sel0, 8'h2A);

    // R9: read-only and unimplemented addresses
    write_reg("R9 w3", 8'h03, 8'h55, -1);
    write_reg("R9 w6", 8'h06, 8'h11, -1);
    read_reg("R9 r3", 8'h03, 8'h81);
    read_reg("R9 r7", 8'h07, 8'h00);

    // R7: status byte from inputs
    st = 7'b1010011;
    tick(5);
    read_reg("R7 mon", 8'h05, 8'hA3);

    // R6: soft reset, then R7 sticky flag
    write_reg("R6 srst", 8'h02, 8'h04, -1);
    check("R6 sel0", sel0, DEF_SEL);
    check("R6 sel1", sel1, DEF_SEL);
    check("R6 ctrl", ctrl, DEF_CTRL);
    read_reg("R7 flag set", 8'h05, 8'hA7);
    read_reg("R7 flag clr", 8'h05, 8'hA3);

    // R8: master code, then write after repeated start
    bus_start();
    send_byte(8'h0A, -1, ack); check("R8 mc nack", ack, 1'b0);
    check("R8 hs on", hs_mode, 1'b1);
    bus_rstart();
    send_byte(8'hC0, -1, ack); check("R8 addr ack", ack, 1'b1);
    send_byte(8'h01, -1, ack); check("R8 reg ack", ack, 1'b1);
    send_byte(8'h33, -1, ack); check("R8 data ack", ack, 1'b1);
    check("R8 hs held", hs_mode, 1'b1);
    bus_stop();
    tick(10);
    check("R8 hs off", hs_mode, 1'b0);
    model_write(8'h01, 8'h33);
    settle();
    check("R8 sel1", sel1, 8'h33);

    // R10: short SDA dip while SCL high inside a data byte
    write_reg("R10 glitch", 8'h00, 8'hC3, 7);
    check("R10 sel0", sel0, 8'hC3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule